// File: doc/BRIEF.md
# Binary32 Multi-Mode Rounding Stage

This stage sits at the end of a floating-point datapath. It receives a result that is already normalised but not yet rounded. The result arrives as a sign, a biased exponent, a 24-bit significand with the hidden bit at the top, and the three bits below the significand: guard, round and sticky. A 3-bit mode input selects one of seven rounding behaviours. These are the five standard IEEE directions plus two round-to-odd variants. The two odd variants differ only in the sign they give to an exact zero whose sign the arithmetic left open.

The stage works out a per-mode increment decision and adds it to the significand. A carry out of an all-ones significand is passed into the exponent. A result whose exponent is above the largest normal value is replaced by infinity or by the largest finite magnitude, depending on mode and sign. The stage packs the binary32 word and raises the inexact and overflow bits of a 5-bit status vector. All outputs are registered, with a latency of one clock. The exponent input is one bit wider than the field, so an upstream stage can also pass in results that have already overflowed.

Top module: `fpr_round_unit`

## Requirements
- R1: Outputs are registered. `out_valid`, `out_value` and `out_flags` show the result for the inputs sampled at the previous rising edge, and `out_valid` copies `in_valid` from that edge. A synchronous high `rst` clears all three to zero.
- R2: Mode code 3'b000 (nearest, ties to even) increments when guard is 1 and at least one of round, sticky or significand bit 0 is 1. Code 3'b111 behaves exactly like 3'b000.
- R3: Mode code 3'b001 (toward zero) never increments, and it never produces an infinity.
- R4: Mode code 3'b010 (toward +inf) increments when the sign is 0 and any of guard/round/sticky is 1. Mode code 3'b011 (toward -inf) does the same when the sign is 1.
- R5: Mode code 3'b100 (nearest, ties away) increments whenever guard is 1.
- R6: Mode codes 3'b101 and 3'b110 (round to odd) increment only when significand bit 0 is 0 and any of guard/round/sticky is 1. An inexact result therefore always has fraction bit 0 set.
- R7: Incrementing an all-ones significand gives a fraction of zero and an exponent one higher.
- R8: When the rounded exponent exceeds 2^8-2, the output is infinity in the following cases: codes 000, 100 and 111 for either sign, code 010 when positive, and code 011 when negative. In every other case the output is the largest finite value of the same sign (exponent 254, fraction all ones).
- R9: With `in_zero` high, the output is a zero with flags 0, and `in_sign` is ignored. The zero is negative for codes 011 and 110 and positive for all other codes.
- R10: The flags use bit 4 for invalid, bit 3 for divide-by-zero, bit 2 for overflow, bit 1 for underflow and bit 0 for inexact. Bit 0 is set when any of guard/round/sticky is 1 or when overflow occurs. Bit 2 is set on overflow as defined in R8. Bits 4, 3 and 1 are always 0.
- R11: The output word is {sign, exponent[7:0], fraction[22:0]}. The fraction is the rounded significand without its hidden bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input fields carry a result this cycle |
| in_sign | input | 1 | Sign of the unrounded result |
| in_exp | input | 9 | Biased exponent, values above 254 mean overflow |
| in_sig | input | 24 | Normalised significand, hidden bit at bit 23 |
| in_guard | input | 1 | First bit below the significand |
| in_round | input | 1 | Second bit below the significand |
| in_sticky | input | 1 | OR of all lower discarded bits |
| in_zero | input | 1 | Result is an exact zero with undetermined sign |
| in_mode | input | 3 | Rounding mode code |
| out_valid | output | 1 | Registered copy of in_valid |
| out_value | output | 32 | Rounded binary32 result |
| out_flags | output | 5 | Status flags |

## Verification
Every result is due exactly one rising edge after the inputs that produce it, because the only register on the path is the output stage. The bench changes inputs on the falling edge. It compares value, flags and valid on the next falling edge against a behavioural model that was evaluated when those inputs were applied. Back-to-back stimuli with different modes therefore also check that no state leaks from one cycle into the next.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'b000,
    RM_TO_ZERO   = 3'b001,
    RM_TO_POS    = 3'b010,
    RM_TO_NEG    = 3'b011,
    RM_NEAR_AWAY = 3'b100,
    RM_ODD_POS   = 3'b101,
    RM_ODD_NEG   = 3'b110,
    RM_SPARE     = 3'b111
  } rmode_e;

  localparam int FLAG_W       = 5;
  localparam int FLAG_INVALID = 4;
  localparam int FLAG_DIVZERO = 3;
  localparam int FLAG_OVERFL  = 2;
  localparam int FLAG_UNDERFL = 1;
  localparam int FLAG_INEXACT = 0;

  // per-cycle rounding decision handed from the decider to the packer
  typedef struct packed {
    logic inc;        // add one ulp to the significand
    logic inexact;    // discarded bits were non-zero
    logic ovf_inf;    // on overflow, saturate to infinity (else max finite)
    logic zero_neg;   // sign of an undetermined zero
  } rdec_t;

endpackage

// File: rtl/fpr_decide.sv
module fpr_decide
  import fpr_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       sign,
  input  logic       lsb,
  input  logic       guard,
  input  logic       rnd,
  input  logic       sticky,
  output rdec_t      dec
);

  logic lost;
  rmode_e rm;

  assign lost = guard | rnd | sticky;
  assign rm   = rmode_e'(mode);

  always_comb begin
    dec          = '0;
    dec.inexact  = lost;
    unique case (rm)
      RM_NEAR_EVEN, RM_SPARE: begin
        dec.inc     = guard & (rnd | sticky | lsb);
        dec.ovf_inf = 1'b1;
      end
      RM_TO_ZERO: begin
        dec.inc     = 1'b0;
        dec.ovf_inf = 1'b0;
      end
      RM_TO_POS: begin
        dec.inc     = ~sign & lost;
        dec.ovf_inf = ~sign;
      end
      RM_TO_NEG: begin
        dec.inc      = sign & lost;
        dec.ovf_inf  = sign;
        dec.zero_neg = 1'b1;
      end
      RM_NEAR_AWAY: begin
        dec.inc     = guard;
        dec.ovf_inf = 1'b1;
      end
      RM_ODD_POS: begin
        dec.inc     = ~lsb & lost;
        dec.ovf_inf = 1'b0;
      end
      RM_ODD_NEG: begin
        dec.inc      = ~lsb & lost;
        dec.ovf_inf  = 1'b0;
        dec.zero_neg = 1'b1;
      end
      default: dec = '0;
    endcase
  end

endmodule

// File: rtl/fpr_incr.sv
module fpr_incr #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [FRAC_W:0]  sig,
  input  logic [EXP_W:0]   exp_i,
  input  logic             inc,
  output logic [FRAC_W-1:0] frac_o,
  output logic [EXP_W+1:0] exp_o
);

  localparam int XW = EXP_W + 2;

  logic carry;

  // an all-ones significand that is incremented wraps the fraction to zero
  assign carry  = inc & (&sig);
  assign frac_o = sig[FRAC_W-1:0] + {{(FRAC_W-1){1'b0}}, inc};
  assign exp_o  = {1'b0, exp_i} + {{(XW-1){1'b0}}, carry};

endmodule

// File: rtl/fpr_pack.sv
module fpr_pack
  import fpr_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    sign,
  input  logic                    zero,
  input  logic [EXP_W+1:0]        exp_r,
  input  logic [FRAC_W-1:0]       frac_r,
  input  rdec_t                   dec,
  output logic [EXP_W+FRAC_W:0]   value,
  output logic [FLAG_W-1:0]       flags
);

  localparam int XW = EXP_W + 2;
  localparam logic [XW-1:0] EXP_TOP = XW'((1 << EXP_W) - 2);

  logic ovf;

  assign ovf = exp_r > EXP_TOP;

  always_comb begin
    value = '0;
    flags = '0;
    if (zero) begin
      value = {dec.zero_neg, {(EXP_W+FRAC_W){1'b0}}};
    end else if (ovf) begin
      flags[FLAG_OVERFL] = 1'b1;
      flags[FLAG_INEXACT] = 1'b1;
      if (dec.ovf_inf)
        value = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else
        value = {sign, EXP_TOP[EXP_W-1:0], {FRAC_W{1'b1}}};
    end else begin
      flags[FLAG_INEXACT] = dec.inexact;
      value = {sign, exp_r[EXP_W-1:0], frac_r};
    end
  end

endmodule

// File: rtl/fpr_round_unit.sv
module fpr_round_unit
  import fpr_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic                  in_sign,
  input  logic [EXP_W:0]        in_exp,
  input  logic [FRAC_W:0]       in_sig,
  input  logic                  in_guard,
  input  logic                  in_round,
  input  logic                  in_sticky,
  input  logic                  in_zero,
  input  logic [2:0]            in_mode,
  output logic                  out_valid,
  output logic [EXP_W+FRAC_W:0] out_value,
  output logic [FLAG_W-1:0]     out_flags
);

  localparam int WORD_W = EXP_W + FRAC_W + 1;

  rdec_t              dec;
  logic [FRAC_W-1:0]  frac_r;
  logic [EXP_W+1:0]   exp_r;
  logic [WORD_W-1:0]  value_d;
  logic [FLAG_W-1:0]  flags_d;

  fpr_decide u_decide (
    .mode   (in_mode),
    .sign   (in_sign),
    .lsb    (in_sig[0]),
    .guard  (in_guard),
    .rnd    (in_round),
    .sticky (in_sticky),
    .dec    (dec)
  );

  fpr_incr #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_incr (
    .sig    (in_sig),
    .exp_i  (in_exp),
    .inc    (dec.inc),
    .frac_o (frac_r),
    .exp_o  (exp_r)
  );

  fpr_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_pack (
    .sign   (in_sign),
    .zero   (in_zero),
    .exp_r  (exp_r),
    .frac_r (frac_r),
    .dec    (dec),
    .value  (value_d),
    .flags  (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_value <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= in_valid;
      out_value <= value_d;
      out_flags <= flags_d;
    end
  end

endmodule

// File: rtl/fpr_round_chk.sv
module fpr_round_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  in_zero,
  input logic [2:0]            in_mode,
  input logic                  out_valid,
  input logic [EXP_W+FRAC_W:0] out_value,
  input logic [4:0]            out_flags
);

  // R1
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid && !rst));

  // R10
  reserved_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (out_flags[4:3] == 2'b00) && !out_flags[1]);

  // R10
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (rst)
    out_flags[2] |-> out_flags[0]);

  // R8
  inf_needs_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (out_value[EXP_W+FRAC_W-1:FRAC_W] == {EXP_W{1'b1}}) |-> out_flags[2]);

  // R3
  tz_no_inf_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && !in_zero && in_mode == 3'b001 && !rst)
      |-> out_value[EXP_W+FRAC_W-1:FRAC_W] != {EXP_W{1'b1}});

  // R6
  odd_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(in_valid && !in_zero && (in_mode == 3'b101 || in_mode == 3'b110) && !rst)
      && out_flags[0]) |-> out_value[0]);

  // R9
  zero_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_zero && !rst)
      |-> (out_value[EXP_W+FRAC_W-1:0] == '0) && (out_flags == 5'b0));

endmodule

bind fpr_round_unit fpr_round_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_zero   (in_zero),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_value (out_value),
  .out_flags (out_flags)
);

// File: tb/fpr_round_unit_bench.sv
module fpr_round_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sign = 1'b0;
  logic [8:0]  in_exp = '0;
  logic [23:0] in_sig = '0;
  logic        in_guard = 1'b0;
  logic        in_round = 1'b0;
  logic        in_sticky = 1'b0;
  logic        in_zero = 1'b0;
  logic [2:0]  in_mode = '0;
  logic        out_valid;
  logic [31:0] out_value;
  logic [4:0]  out_flags;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fpr_round_unit u_fpr_round_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_sig(in_sig), .in_guard(in_guard),
    .in_round(in_round), .in_sticky(in_sticky), .in_zero(in_zero),
    .in_mode(in_mode), .out_valid(out_valid), .out_value(out_value),
    .out_flags(out_flags)
  );

  // behavioural reference: integer arithmetic on the magnitude
  function automatic void model(input bit s, input int e, input int sig,
                                input bit g, input bit r, input bit st,
                                input bit z, input int mode,
                                output logic [31:0] v, output logic [4:0] f);
    int m;
    bit lost, up, inf_sel;
    int mag, ex;
    m = (mode == 7) ? 0 : mode;
    lost = g | r | st;
    if (z) begin
      v = {((m == 3) || (m == 6)) ? 1'b1 : 1'b0, 31'd0};
      f = 5'd0;
      return;
    end
    case (m)
      0: up = g && (r || st || (sig % 2 == 1));
      1: up = 0;
      2: up = !s && lost;
      3: up = s && lost;
      4: up = g;
      default: up = (sig % 2 == 0) && lost;
    endcase
    mag = sig + (up ? 1 : 0);
    ex = e;
    if (mag >= (1 << 24)) begin
      mag = mag / 2;
      ex = ex + 1;
    end
    if (ex > 254) begin
      inf_sel = (m == 0) || (m == 4) || (m == 2 && !s) || (m == 3 && s);
      v = inf_sel ? {s, 8'hFF, 23'd0} : {s, 8'hFE, 23'h7FFFFF};
      f = 5'b00101;
    end else begin
      v = {s, ex[7:0], mag[22:0]};
      f = {4'd0, lost};
    end
  endfunction

  task automatic check(input string req, input logic [31:0] ev,
                       input logic [4:0] ef, input logic evld);
    n_checks++;
    if (out_value !== ev || out_flags !== ef || out_valid !== evld) begin
      n_fails++;
      $display("FAIL %s: got value=%h flags=%b valid=%b, expected value=%h flags=%b valid=%b",
               req, out_value, out_flags, out_valid, ev, ef, evld);
    end
  endtask

  // apply at a falling edge, result due after the next rising edge
  task automatic step(input string req, input bit vld, input bit s,
                      input int e, input int sig, input bit g, input bit r,
                      input bit st, input bit z, input int mode);
    logic [31:0] ev;
    logic [4:0]  ef;
    in_valid  = vld;
    in_sign   = s;
    in_exp    = e[8:0];
    in_sig    = sig[23:0];
    in_guard  = g;
    in_round  = r;
    in_sticky = st;
    in_zero   = z;
    in_mode   = mode[2:0];
    model(s, e, sig, g, r, st, z, mode, ev, ef);
    @(negedge clk);
    check(req, ev, ef, vld);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    n_checks++;
    if (out_valid !== 1'b0 || out_value !== 32'd0 || out_flags !== 5'd0) begin
      n_fails++;
      $display("FAIL R1 reset: got %b %h %b expected 0 00000000 00000", out_valid, out_value, out_flags);
    end
    rst = 1'b0;

    // R2 nearest even
    step("R2 tie lsb0 stays",   1, 0, 127, 'h800000, 1, 0, 0, 0, 0);
    step("R2 tie lsb1 rounds",  1, 0, 127, 'h800001, 1, 0, 0, 0, 0);
    step("R2 above half",       1, 1, 127, 'h800000, 1, 0, 1, 0, 0);
    step("R2 below half",       1, 0, 127, 'h800001, 0, 1, 1, 0, 0);
    step("R2 code 111 alias",   1, 0, 127, 'h800001, 1, 0, 0, 0, 7);
    step("R10 exact no flag",   1, 0, 100, 'hABCDEF, 0, 0, 0, 0, 0);
    // R3 toward zero
    step("R3 no increment",     1, 0, 127, 'hFFFFFF, 1, 1, 1, 0, 1);
    step("R3 max stays finite", 1, 1, 254, 'hFFFFFF, 1, 1, 1, 0, 1);
    // R4 directed
    step("R4 up positive",      1, 0, 127, 'h800000, 0, 0, 1, 0, 2);
    step("R4 up negative",      1, 1, 127, 'h800000, 0, 0, 1, 0, 2);
    step("R4 down negative",    1, 1, 127, 'h800000, 0, 1, 0, 0, 3);
    step("R4 down positive",    1, 0, 127, 'h800000, 0, 1, 0, 0, 3);
    // R5 nearest away
    step("R5 tie away",         1, 0, 127, 'h800000, 1, 0, 0, 0, 4);
    step("R5 below half",       1, 1, 127, 'h800000, 0, 1, 1, 0, 4);
    // R6 round to odd
    step("R6 odd pos lsb0",     1, 0, 127, 'h800000, 0, 0, 1, 0, 5);
    step("R6 odd pos lsb1",     1, 0, 127, 'h800001, 1, 0, 0, 0, 5);
    step("R6 odd neg lsb0",     1, 1, 127, 'h812340, 1, 1, 0, 0, 6);
    step("R6 odd exact",        1, 0, 127, 'h800000, 0, 0, 0, 0, 6);
    // R7 carry into exponent
    step("R7 carry",            1, 0, 127, 'hFFFFFF, 1, 1, 0, 0, 0);
    step("R7 carry down mode",  1, 1, 3,   'hFFFFFF, 0, 0, 1, 0, 3);
    // R8 overflow selection
    step("R8 carry to inf",     1, 0, 254, 'hFFFFFF, 1, 0, 1, 0, 0);
    step("R8 tz neg max",       1, 1, 300, 'h800000, 0, 0, 0, 0, 1);
    step("R8 up neg max",       1, 1, 300, 'h800000, 0, 0, 0, 0, 2);
    step("R8 up pos inf",       1, 0, 300, 'h800000, 0, 0, 0, 0, 2);
    step("R8 down neg inf",     1, 1, 511, 'h800000, 0, 0, 0, 0, 3);
    step("R8 away neg inf",     1, 1, 255, 'h800000, 0, 0, 0, 0, 4);
    step("R8 odd pos max",      1, 0, 255, 'h800000, 0, 0, 0, 0, 5);
    step("R8 odd neg max carry",1, 1, 254, 'hFFFFFE, 0, 1, 0, 0, 6);
    // R9 undetermined zero
    step("R9 down zero neg",    1, 0, 0, 0, 0, 0, 0, 1, 3);
    step("R9 odd neg zero",     1, 0, 0, 0, 0, 0, 0, 1, 6);
    step("R9 odd pos zero",     1, 1, 0, 0, 0, 0, 0, 1, 5);
    step("R9 even zero ignores sign", 1, 1, 0, 0, 1, 1, 1, 1, 0);
    // R11 field placement
    step("R11 packing",         1, 1, 200, 'hC00005, 0, 0, 0, 0, 1);
    // R1 valid low
    step("R1 valid low",        0, 0, 127, 'h800000, 0, 0, 0, 0, 0);
    step("R1 valid high again", 1, 0, 127, 'h800000, 0, 0, 0, 0, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL R1 watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule